// File: doc/BRIEF.md
# Strap-Latched Clock Mode Decoder

This block sits beside a clock generator and turns its board straps into a clock plan. One input is a three-level mode strap, which arrives already resolved into two bits. The other straps are two frequency-select bits and a current-multiplier select bit. All straps are read once, on the first clock edge at which the active-low power-good strobe is seen low. After that capture the configuration is frozen. Later activity on the strobe or the straps has no effect until reset.

From the frozen straps the block produces the following:
- an enumerated frequency source for each of seven output groups: CPU, internal 66 MHz, buffered 66 MHz, PCI, reference, USB and DOT;
- one output enable per group;
- a flag that turns the shared 66 MHz pin into an input;
- a flag for reserved strap codes.

In test mode, the clock input is the test clock. A synchronous counter divides it by 2, by 4 and by 8. The counter is cleared on the capture edge, so all divided outputs start in phase.

Top module: `clk_mode_strap_dec`

## Requirements
- R1: Before capture, and after reset, the outputs are as follows: `cfg_valid`, `cfg_reserved`, `ext66_sel` and `test_active` are 0; every `grp_oe` bit is 0; every group source is OFF (code 0); `tclk_div` is 0.
- R2: The straps are captured on the first rising edge of `clk` at which `pwr_good_n` is 0. After that edge, `cfg_valid` is 1, and `cfg_mode`, `cfg_fsel` and `cfg_mult` equal the `mode_lvl`, `fsel` and `mult_sel` values present at that edge.
- R3: Once `cfg_valid` is 1, later values of `pwr_good_n`, `mode_lvl`, `fsel` and `mult_sel` change no output, except the running test divider.
- R4: With the mode strap low (`mode_lvl`=00) or high (10), `cpu_src` follows the frequency-select value: 00 gives code 4 (66 MHz), 01 gives 5 (100 MHz), 10 gives 7 (200 MHz), 11 gives 6 (133 MHz).
- R5: With the mode strap high, the outputs are as follows: `ext66_sel`=1, `buf_src`=8 (follows the external 66 MHz input), `pci_src`=9 (external input divided by 2), `v66_src`=4.
- R6: With the mode strap low, the outputs are as follows: `ext66_sel`=0, `v66_src`=`buf_src`=4, `pci_src`=2 (33 MHz).
- R7: In both normal modes, the outputs are as follows: `ref_src`=1 (14.318 MHz), `usb_src`=`dot_src`=3 (48 MHz), all seven `grp_oe` bits are 1.
- R8: With the mode strap mid (01) and `fsel`=00, every group is in high impedance: `grp_oe`=0, all sources 0, `cfg_reserved`=0, `test_active`=0.
- R9: With the mode strap mid and `fsel`=01, test mode applies: `test_active`=1 and all `grp_oe` bits are 1. The sources are: `cpu_src`=11 (test clock/2), `v66_src`=`buf_src`=12 (/4), `pci_src`=13 (/8), `ref_src`=`usb_src`=10 (test clock), `dot_src`=11.
- R10: A mid mode strap with `fsel` 10 or 11, and the unused mode code 11, give `cfg_reserved`=1, `grp_oe`=0 and all sources 0.
- R11: In test mode, `tclk_div` holds the count of clock edges since the capture edge, modulo 8. It reads 0 in the first cycle after capture. Bit 0 is the test clock /2, bit 1 is /4 and bit 2 is /8. In every other mode `tclk_div` stays 0.
- R12: `grp_oe` bit order is CPU, internal 66, buffered 66, PCI, reference, USB, DOT, from bit 0 to bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; carries the test clock in test mode |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good_n | input | 1 | Active-low strobe; first low captures the straps |
| mode_lvl | input | 2 | Resolved three-level mode strap: 00 low, 01 mid, 10 high |
| fsel | input | 2 | Frequency-select straps |
| mult_sel | input | 1 | Current-multiplier select strap |
| cfg_valid | output | 1 | Straps have been captured |
| cfg_mode | output | 2 | Captured mode strap |
| cfg_fsel | output | 2 | Captured frequency select |
| cfg_mult | output | 1 | Captured multiplier select |
| cfg_reserved | output | 1 | Captured code is reserved |
| ext66_sel | output | 1 | Shared 66 MHz pin acts as an input |
| test_active | output | 1 | Test-clock divider mode selected |
| cpu_src | output | 4 | CPU group source code |
| v66_src | output | 4 | Internal 66 MHz group source code |
| buf_src | output | 4 | Buffered 66 MHz group source code |
| pci_src | output | 4 | PCI group source code |
| ref_src | output | 4 | Reference group source code |
| usb_src | output | 4 | USB group source code |
| dot_src | output | 4 | DOT group source code |
| grp_oe | output | 7 | Per-group output enable |
| tclk_div | output | DIV_STAGES | Test clock divided by 2, 4, 8 |

## Verification
Two events can fall on the same edge: the capture of the straps and the first step of the test divider. The capture edge must clear the counter rather than advance it. A second case is a strobe that stays low, or pulses again, while the straps change. The bench provokes both. In every mode and frequency-select combination, it drops the strobe for one cycle and then flips all straps and toggles the strobe again. A behavioural model counts the edges since capture. The bench compares every output with that model on every cycle, so the divider must read 0 right after capture and the frozen configuration must not move.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

    typedef enum logic [3:0] {
        F_OFF     = 4'd0,
        F_14M     = 4'd1,
        F_33M     = 4'd2,
        F_48M     = 4'd3,
        F_66M     = 4'd4,
        F_100M    = 4'd5,
        F_133M    = 4'd6,
        F_200M    = 4'd7,
        F_EXT     = 4'd8,
        F_EXT_D2  = 4'd9,
        F_T1      = 4'd10,
        F_T2      = 4'd11,
        F_T4      = 4'd12,
        F_T8      = 4'd13
    } freq_t;

    localparam logic [1:0] LVL_LOW  = 2'b00;
    localparam logic [1:0] LVL_MID  = 2'b01;
    localparam logic [1:0] LVL_HIGH = 2'b10;

    localparam int NUM_GRP  = 7;
    localparam int SRC_W    = 4;
    localparam int GRP_CPU  = 0;
    localparam int GRP_V66  = 1;
    localparam int GRP_BUF  = 2;
    localparam int GRP_PCI  = 3;
    localparam int GRP_REF  = 4;
    localparam int GRP_USB  = 5;
    localparam int GRP_DOT  = 6;

    typedef struct packed {
        logic       valid;
        logic [1:0] lvl;
        logic [1:0] fsel;
        logic       mult;
    } straps_t;

endpackage

// File: rtl/strap_latch.sv
module strap_latch
    import clkmode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pg_n,
    input  logic [1:0] lvl,
    input  logic [1:0] fsel,
    input  logic       mult,
    output straps_t    st_o,
    output logic       capture_o
);

    straps_t st_d, st_q;
    logic    cap_d;

    always_comb begin
        st_d  = st_q;
        cap_d = !st_q.valid && !pg_n;
        if (cap_d) begin
            st_d.valid = 1'b1;
            st_d.lvl   = lvl;
            st_d.fsel  = fsel;
            st_d.mult  = mult;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign st_o      = st_q;
    assign capture_o = cap_d;

endmodule

// File: rtl/mode_decode.sv
module mode_decode
    import clkmode_pkg::*;
(
    input  straps_t                          st,
    output logic [NUM_GRP-1:0][SRC_W-1:0]    src_o,
    output logic [NUM_GRP-1:0]               oe_o,
    output logic                             resv_o,
    output logic                             ext66_o,
    output logic                             test_o
);

    freq_t cpu_f;

    always_comb begin
        unique case (st.fsel)
            2'b00:   cpu_f = F_66M;
            2'b01:   cpu_f = F_100M;
            2'b10:   cpu_f = F_200M;
            default: cpu_f = F_133M;
        endcase
    end

    always_comb begin
        src_o   = '0;
        oe_o    = '0;
        resv_o  = 1'b0;
        ext66_o = 1'b0;
        test_o  = 1'b0;
        if (st.valid) begin
            unique case (st.lvl)
                LVL_LOW, LVL_HIGH: begin
                    oe_o           = '1;
                    src_o[GRP_CPU] = cpu_f;
                    src_o[GRP_V66] = F_66M;
                    src_o[GRP_REF] = F_14M;
                    src_o[GRP_USB] = F_48M;
                    src_o[GRP_DOT] = F_48M;
                    if (st.lvl == LVL_HIGH) begin
                        ext66_o        = 1'b1;
                        src_o[GRP_BUF] = F_EXT;
                        src_o[GRP_PCI] = F_EXT_D2;
                    end else begin
                        src_o[GRP_BUF] = F_66M;
                        src_o[GRP_PCI] = F_33M;
                    end
                end
                LVL_MID: begin
                    unique case (st.fsel)
                        2'b00: ;
                        2'b01: begin
                            test_o         = 1'b1;
                            oe_o           = '1;
                            src_o[GRP_CPU] = F_T2;
                            src_o[GRP_V66] = F_T4;
                            src_o[GRP_BUF] = F_T4;
                            src_o[GRP_PCI] = F_T8;
                            src_o[GRP_REF] = F_T1;
                            src_o[GRP_USB] = F_T1;
                            src_o[GRP_DOT] = F_T2;
                        end
                        default: resv_o = 1'b1;
                    endcase
                end
                default: resv_o = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/tclk_divider.sv
module tclk_divider #(
    parameter int STAGES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              run,
    output logic [STAGES-1:0] div_o
);

    typedef struct packed {
        logic [STAGES-1:0] cnt;
    } div_state_t;

    div_state_t dv_d, dv_q;

    always_comb begin
        dv_d = dv_q;
        if (restart) begin
            dv_d.cnt = '0;
        end else if (run) begin
            dv_d.cnt = dv_q.cnt + 1'b1;
        end else begin
            dv_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dv_q <= '0;
        end else begin
            dv_q <= dv_d;
        end
    end

    for (genvar i = 0; i < STAGES; i++) begin : g_tap
        assign div_o[i] = dv_q.cnt[i];
    end

endmodule

// File: rtl/clk_mode_strap_dec.sv
module clk_mode_strap_dec
    import clkmode_pkg::*;
#(
    parameter int DIV_STAGES = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pwr_good_n,
    input  logic [1:0]            mode_lvl,
    input  logic [1:0]            fsel,
    input  logic                  mult_sel,
    output logic                  cfg_valid,
    output logic [1:0]            cfg_mode,
    output logic [1:0]            cfg_fsel,
    output logic                  cfg_mult,
    output logic                  cfg_reserved,
    output logic                  ext66_sel,
    output logic                  test_active,
    output logic [3:0]            cpu_src,
    output logic [3:0]            v66_src,
    output logic [3:0]            buf_src,
    output logic [3:0]            pci_src,
    output logic [3:0]            ref_src,
    output logic [3:0]            usb_src,
    output logic [3:0]            dot_src,
    output logic [6:0]            grp_oe,
    output logic [DIV_STAGES-1:0] tclk_div
);

    straps_t                       st;
    logic                          capture;
    logic [NUM_GRP-1:0][SRC_W-1:0] src;
    logic [NUM_GRP-1:0]            oe;
    logic                          test;

    strap_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .pg_n      (pwr_good_n),
        .lvl       (mode_lvl),
        .fsel      (fsel),
        .mult      (mult_sel),
        .st_o      (st),
        .capture_o (capture)
    );

    mode_decode u_dec (
        .st      (st),
        .src_o   (src),
        .oe_o    (oe),
        .resv_o  (cfg_reserved),
        .ext66_o (ext66_sel),
        .test_o  (test)
    );

    tclk_divider #(.STAGES(DIV_STAGES)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (capture),
        .run     (test),
        .div_o   (tclk_div)
    );

    assign cfg_valid   = st.valid;
    assign cfg_mode    = st.lvl;
    assign cfg_fsel    = st.fsel;
    assign cfg_mult    = st.mult;
    assign test_active = test;
    assign grp_oe      = oe;
    assign cpu_src     = src[GRP_CPU];
    assign v66_src     = src[GRP_V66];
    assign buf_src     = src[GRP_BUF];
    assign pci_src     = src[GRP_PCI];
    assign ref_src     = src[GRP_REF];
    assign usb_src     = src[GRP_USB];
    assign dot_src     = src[GRP_DOT];

endmodule

// File: rtl/clk_mode_strap_chk.sv
module clk_mode_strap_chk #(
    parameter int DIV_STAGES = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  pwr_good_n,
    input logic [1:0]            fsel,
    input logic                  cfg_valid,
    input logic [1:0]            cfg_mode,
    input logic [1:0]            cfg_fsel,
    input logic                  cfg_mult,
    input logic                  cfg_reserved,
    input logic                  test_active,
    input logic [6:0]            grp_oe,
    input logic [DIV_STAGES-1:0] tclk_div
);

    // R1
    no_oe_before_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |-> (grp_oe == '0));

    // R2
    capture_fsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_valid && !pwr_good_n) |=> (cfg_valid && cfg_fsel == $past(fsel)));

    // R3
    frozen_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> (cfg_valid && $stable(cfg_mode) && $stable(cfg_fsel) && $stable(cfg_mult)));

    // R10
    reserved_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_reserved |-> (grp_oe == '0 && !test_active));

    // R11
    div_start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_valid) |-> (tclk_div == '0));

    // R11
    div_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_active && $past(test_active)) |-> (tclk_div[0] != $past(tclk_div[0])));

    // R11
    div_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !test_active |-> (tclk_div == '0));

endmodule

bind clk_mode_strap_dec clk_mode_strap_chk #(.DIV_STAGES(DIV_STAGES)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_good_n   (pwr_good_n),
    .fsel         (fsel),
    .cfg_valid    (cfg_valid),
    .cfg_mode     (cfg_mode),
    .cfg_fsel     (cfg_fsel),
    .cfg_mult     (cfg_mult),
    .cfg_reserved (cfg_reserved),
    .test_active  (test_active),
    .grp_oe       (grp_oe),
    .tclk_div     (tclk_div)
);

// File: tb/clk_mode_strap_dec_tb_top.sv
module clk_mode_strap_dec_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_good_n = 1'b1;
    logic [1:0] mode_lvl = 2'b00;
    logic [1:0] fsel = 2'b00;
    logic       mult_sel = 1'b0;

    logic       cfg_valid, cfg_mult, cfg_reserved, ext66_sel, test_active;
    logic [1:0] cfg_mode, cfg_fsel;
    logic [3:0] cpu_src, v66_src, buf_src, pci_src, ref_src, usb_src, dot_src;
    logic [6:0] grp_oe;
    logic [2:0] tclk_div;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    clk_mode_strap_dec dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_good_n(pwr_good_n), .mode_lvl(mode_lvl),
        .fsel(fsel), .mult_sel(mult_sel), .cfg_valid(cfg_valid), .cfg_mode(cfg_mode),
        .cfg_fsel(cfg_fsel), .cfg_mult(cfg_mult), .cfg_reserved(cfg_reserved),
        .ext66_sel(ext66_sel), .test_active(test_active), .cpu_src(cpu_src),
        .v66_src(v66_src), .buf_src(buf_src), .pci_src(pci_src), .ref_src(ref_src),
        .usb_src(usb_src), .dot_src(dot_src), .grp_oe(grp_oe), .tclk_div(tclk_div)
    );

    // Behavioural reference state
    bit         m_valid;
    bit  [1:0]  m_mode, m_fsel;
    bit         m_mult;
    int         m_edges;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_valid <= 0; m_mode <= 0; m_fsel <= 0; m_mult <= 0; m_edges <= 0;
        end else if (!m_valid && !pwr_good_n) begin
            m_valid <= 1; m_mode <= mode_lvl; m_fsel <= fsel; m_mult <= mult_sel;
            m_edges <= 0;
        end else if (m_valid) begin
            m_edges <= m_edges + 1;
        end
    end

    function automatic bit is_test();
        return m_valid && m_mode == 2'b01 && m_fsel == 2'b01;
    endfunction

    function automatic bit is_normal();
        return m_valid && (m_mode == 2'b00 || m_mode == 2'b10);
    endfunction

    // cpu,v66,buf,pci,ref,usb,dot packed from low nibble up
    function automatic logic [27:0] exp_src();
        logic [27:0] v = '0;
        int cpu_tab[4] = '{4, 5, 7, 6};
        if (is_normal()) begin
            v[3:0]   = 4'(cpu_tab[m_fsel]);
            v[7:4]   = 4;
            v[11:8]  = (m_mode == 2'b10) ? 4'd8 : 4'd4;
            v[15:12] = (m_mode == 2'b10) ? 4'd9 : 4'd2;
            v[19:16] = 1;
            v[23:20] = 3;
            v[27:24] = 3;
        end else if (is_test()) begin
            v = {4'd11, 4'd10, 4'd10, 4'd13, 4'd12, 4'd12, 4'd11};
        end
        return v;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [27:0] es = exp_src();
        bit resv = m_valid && (m_mode == 2'b11 || (m_mode == 2'b01 && m_fsel[1]));
        logic [2:0] ediv = is_test() ? 3'(m_edges % 8) : 3'd0;
        chk("R1/R2", "cfg_valid", 32'(cfg_valid), 32'(m_valid));
        if (m_valid) begin
            chk("R2/R3", "cfg_mode", 32'(cfg_mode), 32'(m_mode));
            chk("R2/R3", "cfg_fsel", 32'(cfg_fsel), 32'(m_fsel));
            chk("R2/R3", "cfg_mult", 32'(cfg_mult), 32'(m_mult));
        end
        chk("R4-cpu", "cpu_src", 32'(cpu_src), 32'(es[3:0]));
        chk("R5/R6", "v66/buf/pci", 32'({pci_src, buf_src, v66_src}), 32'(es[15:4]));
        chk("R7/R9", "ref/usb/dot", 32'({dot_src, usb_src, ref_src}), 32'(es[27:16]));
        chk("R5", "ext66_sel", 32'(ext66_sel), 32'(m_valid && m_mode == 2'b10));
        chk("R10", "cfg_reserved", 32'(cfg_reserved), 32'(resv));
        chk("R9", "test_active", 32'(test_active), 32'(is_test()));
        chk("R8/R12", "grp_oe", 32'(grp_oe), (is_normal() || is_test()) ? 32'h7f : 32'h0);
        chk("R11", "tclk_div", 32'(tclk_div), 32'(ediv));
    endtask

    always @(negedge clk) if (rst_n) compare_all();

    task automatic run_case(input logic [1:0] m, input logic [1:0] f, input logic mu,
                            input bool_hold);
        @(negedge clk);
        rst_n = 1'b0; pwr_good_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            mode_lvl = 2'(i); fsel = 2'(3 - i); mult_sel = i[0];
        end
        @(negedge clk);
        mode_lvl = m; fsel = f; mult_sel = mu; pwr_good_n = 1'b0;
        @(negedge clk);
        mode_lvl = ~m; fsel = ~f; mult_sel = ~mu;
        pwr_good_n = bool_hold ? 1'b0 : 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!bool_hold) pwr_good_n = i[1];
            fsel = 2'(i);
        end
    endtask

    typedef bit bool_hold;

    initial begin
        repeat (2) @(negedge clk);
        // R1: reset state before any capture
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        for (int m = 0; m < 4; m++) begin
            for (int f = 0; f < 4; f++) begin
                run_case(2'(m), 2'(f), 1'(m ^ f), 1'b0);
            end
        end
        // R3: strobe held low through strap changes, test mode and high mode
        run_case(2'b01, 2'b01, 1'b1, 1'b1);
        run_case(2'b10, 2'b11, 1'b0, 1'b1);
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule